// File: doc/BRIEF.md
# Multiword DMA Master Strobe Sequencer

This block runs the host side of a 16-bit multiword DMA burst on a parallel storage-style bus. A burst request names a direction, a word count and one of three timing modes. The sequencer then waits for the device request line and raises the acknowledge. It issues one read or write strobe per word, with the active width and the inactive recovery set by the chosen mode. After the last strobe it holds the acknowledge for a short tail and then releases it.

All bus timing is worked out when the design is built. Each nanosecond limit is turned into clock cycles with a clock-period parameter, rounding up. Each direction has its own recovery time. The recovery time is lengthened whenever active width plus recovery would fall short of the mode's minimum cycle time. Write words are taken from a host port that is told to advance once per strobe. Read words come back on an output with a one-cycle valid pulse.

Top module: `mdma_master`

## Requirements
- R1: Every limit is ceil(ns / CLK_PERIOD_NS) cycles. The strobe active width is 215, 80 and 70 ns for modes 0, 1 and 2. At 5 ns that is 43, 16 and 14 cycles, and it is the same for both directions.
- R2: Recovery is the larger of two values: the per-direction minimum, or the cycle-time minimum (480, 150 and 120 ns) less the active width. The read minimum is 50, 50 and 25 ns. The write minimum is 215, 50 and 25 ns. At 5 ns this gives 53, 14 and 10 cycles in both directions.
- R3: The acknowledge is active for exactly one cycle before the first strobe. It stays active for a tail after the last strobe goes inactive. The tail is max(ceil(dack hold), ceil(write data hold)): hold is 20, 5 and 5 ns and data hold is 20, 15 and 10 ns, so 4, 3 and 2 cycles. No strobe is active while the acknowledge is inactive.
- R4: In a write burst, the data bus is enabled exactly while the acknowledge is active. It is released in the same cycle the acknowledge drops. Each word is latched from wrData as its strobe goes active and held until the next strobe. wrTake pulses in the first active cycle of each write strobe. Read and write strobes are never active together.
- R5: In a read burst, dataIn is captured on the last clock edge of each strobe. It appears on rdData with rdValid high for one cycle, the first cycle after the strobe goes inactive.
- R6: wordsLeft is loaded with wordCount when a burst starts and drops by one at the end of each strobe. After the strobe that brings it to zero, the block goes straight to the acknowledge tail with no recovery. done goes high when the acknowledge is released and clears when the next burst is accepted.
- R7: The device request is sampled at the end of each recovery. If it is inactive, the burst ends there: the acknowledge stays active for the recovery plus the tail after the last strobe.
- R8: dreqPolHigh=1 makes dreqIn active-high, and 0 makes it active-low. dackPolHigh sets the active level of dackOut in the same way.
- R9: Mode and direction are captured when a burst is accepted. Changing modeSel during a burst has no effect on it. modeSel=3 behaves as mode 2.
- R10: A start while a burst is running is ignored. A start with wordCount=0 is ignored: no acknowledge, and done is unchanged.
- R11: After reset both strobes are high, the acknowledge is inactive, the data bus is disabled, and done, rdValid and wrTake are low.
- R12: dreqIn passes through a two-stage synchronizer. While it is inactive no acknowledge is given. The acknowledge goes active in the third cycle after dreqIn becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request pulse |
| isWrite | input | 1 | 1 = write burst, 0 = read burst |
| modeSel | input | 2 | Timing mode 0, 1, 2 (3 acts as 2) |
| wordCount | input | 16 | Words in the burst |
| dreqPolHigh | input | 1 | Device request active level |
| dackPolHigh | input | 1 | Acknowledge active level |
| dreqIn | input | 1 | Device request line |
| dackOut | output | 1 | Acknowledge line |
| diorN | output | 1 | Read strobe, active low |
| diowN | output | 1 | Write strobe, active low |
| wrData | input | 16 | Next write word from host |
| wrTake | output | 1 | Host advances wrData |
| dataOut | output | 16 | Bus write data |
| dataOe | output | 1 | Bus drive enable |
| dataIn | input | 16 | Bus read data |
| rdData | output | 16 | Captured read word |
| rdValid | output | 1 | rdData valid pulse |
| wordsLeft | output | 16 | Words still to transfer |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst finished |

## Verification
The bench measures strobe width, recovery gap, acknowledge lead and acknowledge tail in every mode and both directions. The timing tables are the likeliest place for a rounding or stretching slip, which would show up as a gap of 10 or 43 cycles instead of 53. It changes modeSel and raises start partway through each burst. A design that re-read either input would change width, or restart and overrun the word count. A device request dropped mid-burst must end the burst after the full recovery, not before it. A last word that wrongly passed through recovery would stretch the tail by the recovery length. Inverted request and acknowledge polarities, a zero word count and a withheld request round out the cases.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ACK, ST_ACT, ST_REC, ST_HOLD
  } seqStateT;

  // control-to-datapath strobes
  typedef struct packed {
    logic loadWords;
    logic latchWr;
    logic captureRd;
    logic decWord;
    logic busOn;
    logic strobeOn;
  } ctlStrobesT;

  function automatic int ceilDiv(int ns, int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int cycleNs(int m);
    case (m) 0: return 480; 1: return 150; default: return 120; endcase
  endfunction

  function automatic int activeNs(int m);
    case (m) 0: return 215; 1: return 80; default: return 70; endcase
  endfunction

  function automatic int rdRecNs(int m);
    case (m) 0: return 50; 1: return 50; default: return 25; endcase
  endfunction

  function automatic int wrRecNs(int m);
    case (m) 0: return 215; 1: return 50; default: return 25; endcase
  endfunction

  function automatic int ackHoldNs(int m);
    case (m) 0: return 20; default: return 5; endcase
  endfunction

  function automatic int wrHoldNs(int m);
    case (m) 0: return 20; 1: return 15; default: return 10; endcase
  endfunction

  function automatic int activeCycles(int m, int per);
    return ceilDiv(activeNs(m), per);
  endfunction

  // recovery stretched so active + recovery meets the cycle minimum
  function automatic int recCycles(int m, bit wr, int per);
    int a = ceilDiv(activeNs(m), per);
    int c = ceilDiv(cycleNs(m), per);
    int r = ceilDiv(wr ? wrRecNs(m) : rdRecNs(m), per);
    return (c - a > r) ? c - a : r;
  endfunction

  function automatic int holdCycles(int m, int per);
    int h = ceilDiv(ackHoldNs(m), per);
    int d = ceilDiv(wrHoldNs(m), per);
    return (h > d) ? h : d;
  endfunction

endpackage

// File: rtl/mdma_ctrl.sv
module mdma_ctrl
  import mdma_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int CNT_W         = 8,
  parameter int NUM_MODES     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isWrite,
  input  logic [1:0]       modeSel,
  input  logic             countZero,
  input  logic             dreqActive,
  input  logic             lastWord,
  output ctlStrobesT       ctl,
  output logic             wrDir,
  output logic             busy,
  output logic             done
);

  localparam logic [1:0] TOP_MODE = 2'(NUM_MODES - 1);

  logic [CNT_W-1:0] actTbl   [NUM_MODES];
  logic [CNT_W-1:0] rdRecTbl [NUM_MODES];
  logic [CNT_W-1:0] wrRecTbl [NUM_MODES];
  logic [CNT_W-1:0] holdTbl  [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : gTiming
    assign actTbl[g]   = CNT_W'(activeCycles(g, CLK_PERIOD_NS));
    assign rdRecTbl[g] = CNT_W'(recCycles(g, 1'b0, CLK_PERIOD_NS));
    assign wrRecTbl[g] = CNT_W'(recCycles(g, 1'b1, CLK_PERIOD_NS));
    assign holdTbl[g]  = CNT_W'(holdCycles(g, CLK_PERIOD_NS));
  end

  seqStateT         state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       modeReg;
  logic [1:0]       modeIdx;
  logic [CNT_W-1:0] actLen, recLen, holdLen;
  logic             cntEnd;

  assign modeIdx = (modeSel > TOP_MODE) ? TOP_MODE : modeSel;
  assign actLen  = actTbl[modeReg];
  assign recLen  = wrDir ? wrRecTbl[modeReg] : rdRecTbl[modeReg];
  assign holdLen = holdTbl[modeReg];
  assign cntEnd  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      modeReg <= '0;
      wrDir   <= 1'b0;
      done    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start && !countZero) begin
          state   <= ST_WAIT;
          modeReg <= modeIdx;
          wrDir   <= isWrite;
          done    <= 1'b0;
        end
        ST_WAIT: if (dreqActive) state <= ST_ACK;
        ST_ACK: begin
          state <= ST_ACT;
          cnt   <= actLen - CNT_W'(1);
        end
        ST_ACT: begin
          if (!cntEnd) cnt <= cnt - CNT_W'(1);
          else if (lastWord) begin
            state <= ST_HOLD;
            cnt   <= holdLen - CNT_W'(1);
          end else begin
            state <= ST_REC;
            cnt   <= recLen - CNT_W'(1);
          end
        end
        ST_REC: begin
          if (!cntEnd) cnt <= cnt - CNT_W'(1);
          else if (dreqActive) begin
            state <= ST_ACT;
            cnt   <= actLen - CNT_W'(1);
          end else begin
            state <= ST_HOLD;
            cnt   <= holdLen - CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (!cntEnd) cnt <= cnt - CNT_W'(1);
          else begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadWords = (state == ST_IDLE) && start && !countZero;
    ctl.latchWr   = (state == ST_ACK) || ((state == ST_REC) && cntEnd && dreqActive);
    ctl.decWord   = (state == ST_ACT) && cntEnd;
    ctl.captureRd = ctl.decWord && !wrDir;
    ctl.busOn     = (state == ST_ACK) || (state == ST_ACT) ||
                    (state == ST_REC) || (state == ST_HOLD);
    ctl.strobeOn  = (state == ST_ACT);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mdma_dpath.sv
module mdma_dpath
  import mdma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobesT        ctl,
  input  logic              wrDir,
  input  logic              dreqIn,
  input  logic              dreqPolHigh,
  input  logic              dackPolHigh,
  input  logic [WORD_W-1:0] wordCount,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dreqActive,
  output logic              countZero,
  output logic              lastWord,
  output logic [WORD_W-1:0] wordsLeft,
  output logic              dackOut,
  output logic              diorN,
  output logic              diowN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              wrTake,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic dreqMeta, dreqSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dreqMeta  <= 1'b0;
      dreqSync  <= 1'b0;
      wordsLeft <= '0;
      dataOut   <= '0;
      wrTake    <= 1'b0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      dreqMeta <= dreqIn;
      dreqSync <= dreqMeta;
      if (ctl.loadWords)    wordsLeft <= wordCount;
      else if (ctl.decWord) wordsLeft <= wordsLeft - WORD_W'(1);
      if (ctl.latchWr)      dataOut   <= wrData;
      wrTake  <= ctl.latchWr && wrDir;
      if (ctl.captureRd)    rdData    <= dataIn;
      rdValid <= ctl.captureRd;
    end
  end

  assign dreqActive = dreqPolHigh ? dreqSync : !dreqSync;
  assign countZero  = (wordCount == '0);
  assign lastWord   = (wordsLeft == WORD_W'(1));
  assign dackOut    = dackPolHigh ? ctl.busOn : !ctl.busOn;
  assign diorN      = !(ctl.strobeOn && !wrDir);
  assign diowN      = !(ctl.strobeOn && wrDir);
  assign dataOe     = ctl.busOn && wrDir;

endmodule

// File: rtl/mdma_master.sv
module mdma_master
  import mdma_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int CNT_W         = 8,
  parameter int DATA_W        = 16,
  parameter int WORD_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isWrite,
  input  logic [1:0]        modeSel,
  input  logic [WORD_W-1:0] wordCount,
  input  logic              dreqPolHigh,
  input  logic              dackPolHigh,
  input  logic              dreqIn,
  output logic              dackOut,
  output logic              diorN,
  output logic              diowN,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrTake,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [WORD_W-1:0] wordsLeft,
  output logic              busy,
  output logic              done
);

  ctlStrobesT ctl;
  logic       wrDir, dreqActive, countZero, lastWord;

  mdma_ctrl #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .modeSel(modeSel),
    .countZero(countZero), .dreqActive(dreqActive), .lastWord(lastWord),
    .ctl(ctl), .wrDir(wrDir), .busy(busy), .done(done)
  );

  mdma_dpath #(.DATA_W(DATA_W), .WORD_W(WORD_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrDir(wrDir), .dreqIn(dreqIn),
    .dreqPolHigh(dreqPolHigh), .dackPolHigh(dackPolHigh), .wordCount(wordCount),
    .wrData(wrData), .dataIn(dataIn), .dreqActive(dreqActive), .countZero(countZero),
    .lastWord(lastWord), .wordsLeft(wordsLeft), .dackOut(dackOut), .diorN(diorN),
    .diowN(diowN), .dataOut(dataOut), .dataOe(dataOe), .wrTake(wrTake),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/mdma_master_chk.sv
module mdma_master_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              diorN,
  input logic              diowN,
  input logic              dackOut,
  input logic              dackPolHigh,
  input logic              dataOe,
  input logic              rdValid,
  input logic [WORD_W-1:0] wordsLeft,
  input logic              done
);

  logic dackOn, strobeAny;
  assign dackOn    = (dackOut == dackPolHigh);
  assign strobeAny = !diorN || !diowN;

  AST_STROBE_UNDER_DACK: assert property (@(posedge clk) disable iff (!rstN)
    strobeAny |-> dackOn); // R3
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    !(!diorN && !diowN)); // R4
  AST_OE_WITH_DACK: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> dackOn); // R4
  AST_RDVALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (diorN && !$past(diorN))); // R5
  AST_WORD_DEC: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobeAny) && !strobeAny) |-> (wordsLeft == $past(wordsLeft) - WORD_W'(1))); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !dackOn); // R6

endmodule

bind mdma_master mdma_master_chk #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .diorN(diorN), .diowN(diowN), .dackOut(dackOut),
  .dackPolHigh(dackPolHigh), .dataOe(dataOe), .rdValid(rdValid),
  .wordsLeft(wordsLeft), .done(done)
);

// File: tb/tb_mdma_master.sv
`timescale 1ns/1ps
module tb_mdma_master;

  // mode, write, words, active, recovery, tail
  localparam int VEC [7][6] = '{
    '{0, 0, 3, 43, 53, 4},
    '{0, 1, 2, 43, 53, 4},
    '{1, 0, 3, 16, 14, 3},
    '{1, 1, 2, 16, 14, 3},
    '{2, 0, 4, 14, 10, 2},
    '{2, 1, 2, 14, 10, 2},
    '{3, 1, 2, 14, 10, 2}
  };

  logic        clk = 0, rstN = 0, start = 0, isWrite = 0;
  logic [1:0]  modeSel = 0;
  logic [15:0] wordCount = 0, wrData = 0, dataIn = 0;
  logic        dreqPolHigh = 1, dackPolHigh = 1, dreqIn = 0;
  logic        dackOut, diorN, diowN, wrTake, dataOe, rdValid, busy, done;
  logic [15:0] dataOut, rdData, wordsLeft;

  int nChecks = 0, nFail = 0;

  always #2.5 clk = ~clk;

  mdma_master dut (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .modeSel(modeSel),
    .wordCount(wordCount), .dreqPolHigh(dreqPolHigh), .dackPolHigh(dackPolHigh),
    .dreqIn(dreqIn), .dackOut(dackOut), .diorN(diorN), .diowN(diowN),
    .wrData(wrData), .wrTake(wrTake), .dataOut(dataOut), .dataOe(dataOe),
    .dataIn(dataIn), .rdData(rdData), .rdValid(rdValid), .wordsLeft(wordsLeft),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  function automatic logic dreqLvl(input bit act);
    return act ? dreqPolHigh : !dreqPolHigh;
  endfunction

  function automatic bit dackOn();
    return dackOut == dackPolHigh;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R6", "watchdog expired", 0, 1);
    finishRun();
  end

  task automatic runBurst(input int mode, input int wr, input int words, input int dropAt,
                          input int expPulses, input int expAct, input int expRec,
                          input int expTail, input int expLeft);
    int pulses = 0, firstW = 0, gap = 0, lead = 0, tail = 0, guard = 0;
    int rdSeen = 0, rdBad = 0, wrBad = 0, oeBad = 0, strayBad = 0;
    bit prevLow = 0, low, other;
    modeSel = 2'(mode); isWrite = wr[0]; wordCount = 16'(words);
    wrData = 16'h5001; dataIn = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    modeSel = (mode == 0) ? 2'd2 : 2'd0;  // R9: changed mid-burst
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
      start = 0;
      low   = wr ? !diowN : !diorN;
      other = wr ? !diorN : !diowN;
      if (other) strayBad++;
      if (!dackOn() && dataOe) oeBad++;
      if (low && !prevLow) begin
        pulses++;
        tail = 0;
        if (pulses == 1) begin start = 1; wordCount = 16'd7; end  // R10: busy start
        if (wr) begin
          if (dataOut != 16'(16'h5000 + pulses) || !dataOe) wrBad++;
          if (wrTake) wrData = 16'(16'h5000 + pulses + 1);
        end else dataIn = 16'(16'hA000 + pulses);
        if (pulses == dropAt) dreqIn = dreqLvl(0);
      end
      if (low && pulses == 1) firstW++;
      if (!low && dackOn() && pulses == 0) lead++;
      if (!low && dackOn() && pulses == 1) gap++;
      if (!low && dackOn() && pulses > 0) tail++;
      if (rdValid) begin
        rdSeen++;
        if (rdData != 16'(16'hA000 + rdSeen)) rdBad++;
      end
      prevLow = low;
    end
    dreqIn = dreqLvl(1);
    check(done == 1, "R6", "done at burst end", done, 1);
    check(pulses == expPulses, "R10", "strobe count", pulses, expPulses);
    check(firstW == expAct, "R1", "active width", firstW, expAct);
    if (expPulses > 1) check(gap == expRec, "R2", "recovery gap", gap, expRec);
    check(lead == 1, "R3", "ack lead", lead, 1);
    check(tail == expTail, dropAt > 0 ? "R7" : "R3", "ack tail", tail, expTail);
    check(wordsLeft == 16'(expLeft), "R6", "wordsLeft", int'(wordsLeft), expLeft);
    check(strayBad == 0, "R4", "wrong-direction strobe", strayBad, 0);
    check(oeBad == 0 && dataOe == 0, "R4", "bus enable outside ack", oeBad, 0);
    if (wr) check(wrBad == 0, "R4", "write word mismatches", wrBad, 0);
    else begin
      check(rdSeen == pulses, "R5", "rdValid pulses", rdSeen, pulses);
      check(rdBad == 0, "R5", "read word mismatches", rdBad, 0);
    end
    check(busy == 0, "R9", "busy after mode-changed burst", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check(diorN && diowN, "R11", "strobes idle high", {diorN, diowN}, 3);
    check(!dackOn(), "R11", "ack inactive", dackOut, 0);
    check(!dataOe && !done && !rdValid && !wrTake, "R11", "outputs low",
          {dataOe, done, rdValid, wrTake}, 0);

    // R12: withheld request
    modeSel = 1; isWrite = 0; wordCount = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    begin
      int seenAck = 0, lat = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (dackOn()) seenAck++; end
      check(seenAck == 0, "R12", "ack without request", seenAck, 0);
      dreqIn = dreqLvl(1);
      for (int i = 1; i <= 6 && lat == 0; i++) begin @(negedge clk); if (dackOn()) lat = i; end
      check(lat == 3, "R12", "request-to-ack latency", lat, 3);
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      check(done && wordsLeft == 0, "R6", "single word burst done", int'(wordsLeft), 0);
    end

    // vector table: R1 R2 R3 R4 R5 R9 R10
    for (int v = 0; v < 7; v++)
      runBurst(VEC[v][0], VEC[v][1], VEC[v][2], 0, VEC[v][2],
               VEC[v][3], VEC[v][4], VEC[v][5], 0);

    // R7: request dropped during second strobe, mode 2 read of 10
    runBurst(2, 0, 10, 2, 2, 14, 10, 12, 8);

    // R8: inverted polarities
    dreqPolHigh = 0; dackPolHigh = 0; dreqIn = 1'b0;
    @(negedge clk);
    check(dackOut == 1, "R8", "idle ack level active-low", dackOut, 1);
    repeat (4) @(negedge clk);
    runBurst(1, 0, 2, 0, 2, 16, 14, 3, 0);
    dreqPolHigh = 1; dackPolHigh = 1; dreqIn = 1'b1;
    repeat (4) @(negedge clk);

    // R10: zero word count ignored
    begin
      int ackSeen = 0;
      wordCount = 0;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (dackOn() || busy) ackSeen++; end
      check(ackSeen == 0, "R10", "zero-count start activity", ackSeen, 0);
      check(done == 1, "R10", "done kept", done, 1);
    end

    finishRun();
  end

endmodule